// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single memory requests from a processor core into bus cycles on an external bus. The low address byte and the data byte share one 8-bit bus, and the high address byte has its own 8-bit output. Each cycle starts with an address-latch pulse, leaves a one-unit gap, and then asserts one of three active-low strobes: program fetch, data read or data write. A one-unit hold phase follows. One clock period of the block is one timing unit, which is half an oscillator period.

A request gives a 16-bit address, a write flag, a program/data select and write data. It is accepted in the idle state. Busy stays high until a single-cycle done pulse, and read data is returned with that pulse. A slow device can hold the ready input low to lengthen the strobe. An external-fetch select input decides whether a program fetch from the low, on-chip window runs on the bus or is handled inside the chip. While reset is held, a float-control input decides whether the four control strobes are driven high or released.

Top module: `membus_ctrl`

## Requirements
- R1: While rstN is low, aleOut, psenN, rdN and wrN are all 1 and adOe is 0. strobeOe is 1 when floatCtl is 1 and 0 when floatCtl is 0.
- R2: Out of reset with no cycle running, busy is 0, aleOut is 0, psenN, rdN and wrN are 1, adOe is 0 and strobeOe is 1.
- R3: After a request is accepted on a clock edge in idle, aleOut is 1 for exactly the next 3 cycles. During those cycles adOe is 1, adOut carries address bits [7:0] and addrHi carries bits [15:8]. No strobe is low while aleOut is 1.
- R4: The cycle that follows the address-latch phase has aleOut at 0 and all three strobes high. In that cycle the low address stays driven on adOut with adOe at 1.
- R5: After the gap exactly one strobe goes low for 4 cycles. It is psenN for a program fetch (reqProg=1), rdN for a data read and wrN for a write (reqWrite=1, reqProg=0). addrHi does not change while a strobe is low.
- R6: During a write, adOut carries the write data with adOe at 1 for the whole time wrN is low and for the hold cycle after it.
- R7: During a program fetch or a data read, adOe is 0 while the strobe is low. rdData takes the adIn value present in the last strobe cycle.
- R8: If readyIn is 0 in the last strobe cycle, the strobe stays low for one more cycle. This repeats for every cycle in which readyIn is still 0.
- R9: done is high for exactly one cycle, which is the first cycle after the strobe ends (8 cycles after busy rises when there are no wait states). busy is high from the cycle after acceptance through the done cycle. A request made while busy is ignored.
- R10: When extFetchN is 0, every program fetch runs on the bus. When extFetchN is 1, a program fetch to an address below 0x8000 produces no bus activity and is acknowledged with done in the first cycle after acceptance. A fetch at 0x8000 or above still runs on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one half-oscillator-period unit |
| rstN | input | 1 | Asynchronous active-low reset |
| floatCtl | input | 1 | Reset behaviour of the strobes: 1 drives them high, 0 releases them |
| extFetchN | input | 1 | 0 forces every program fetch onto the external bus |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqProg | input | 1 | 1 selects a program fetch |
| reqWrite | input | 1 | 1 selects a data write |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Captured read or fetch data |
| readyIn | input | 1 | 0 lengthens the strobe phase |
| adIn | input | 8 | Input side of the shared address/data bus |
| adOut | output | 8 | Output side of the shared address/data bus |
| adOe | output | 1 | Output enable of the shared bus |
| addrHi | output | 8 | High address byte |
| aleOut | output | 1 | Address latch pulse, active high |
| psenN | output | 1 | Program fetch strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| strobeOe | output | 1 | Output enable of the four control strobes |

## Verification
The request is presented on a falling clock edge and is accepted on the next rising edge. busy is first seen high one falling edge later, and the monitor numbers the cycles from that point. The address-latch pulse is due at cycles 0 to 2 and the gap at cycle 3. The strobe runs at cycles 4 to 7 plus one cycle per wait, and done falls at cycle 8 plus the number of waits. An internal fetch is due at cycle 0. The scoreboard checks every completion against those numbers, and it checks that the captured address, the strobe counts, the read data and the write data match the values the driver computed. All outputs are sampled on falling clock edges, well away from the rising edge that updates the design.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_GAP,
    ST_STRB,
    ST_HOLD,
    ST_SKIP
  } busState_e;

  // cycle kind, also the index of the strobe it uses
  localparam logic [1:0] KIND_PROG  = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;
  localparam int NUM_STROBES = 3;

  typedef struct packed {
    logic load;       // latch request fields
    logic ale;        // address latch pulse
    logic strobe;     // kind-selected strobe active
    logic driveAddr;  // low address on shared bus
    logic driveData;  // write data may be driven
    logic capture;    // sample read data
  } pathCtl_t;

endpackage

// File: rtl/membus_fsm.sv
module membus_fsm
  import membus_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int ALE_LEN       = 3,
  parameter int GAP_LEN       = 1,
  parameter int STRB_LEN      = 4,
  parameter int INT_ROM_BYTES = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqProg,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              extFetchN,
  input  logic              readyIn,
  output pathCtl_t          ctl,
  output logic              busy,
  output logic              done
);

  localparam int CNT_MAX = (ALE_LEN > STRB_LEN) ?
                           ((ALE_LEN > GAP_LEN) ? ALE_LEN : GAP_LEN) :
                           ((STRB_LEN > GAP_LEN) ? STRB_LEN : GAP_LEN);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ALE_LAST  = CNT_W'(ALE_LEN - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_LEN - 1);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STRB_LEN - 1);
  localparam logic [ADDR_W:0]  ROM_LIMIT = (ADDR_W + 1)'(INT_ROM_BYTES);

  busState_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             internalHit;
  logic             strbLast;

  assign internalHit = reqProg && extFetchN && ({1'b0, reqAddr} < ROM_LIMIT);
  assign strbLast    = (state == ST_STRB) && (cnt == STRB_LAST);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (reqValid) stateNext = internalHit ? ST_SKIP : ST_ALE;
      end
      ST_ALE: begin
        if (cnt == ALE_LAST) begin
          stateNext = ST_GAP;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == GAP_LAST) begin
          stateNext = ST_STRB;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_STRB: begin
        if (cnt != STRB_LAST) cntNext = cnt + 1'b1;
        else if (readyIn)     stateNext = ST_HOLD;
      end
      ST_HOLD: stateNext = ST_IDLE;
      ST_SKIP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && reqValid;
    ctl.ale       = (state == ST_ALE);
    ctl.strobe    = (state == ST_STRB);
    ctl.driveAddr = (state == ST_ALE) || (state == ST_GAP);
    ctl.driveData = (state == ST_STRB) || (state == ST_HOLD);
    ctl.capture   = strbLast && readyIn;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_HOLD) || (state == ST_SKIP);

endmodule

// File: rtl/membus_path.sv
module membus_path
  import membus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              reqProg,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic              aleLvl,
  output logic              psenLvl,
  output logic              rdLvl,
  output logic              wrLvl,
  output logic [DATA_W-1:0] rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [1:0]        kindQ;
  logic [NUM_STROBES-1:0] strbN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      kindQ  <= KIND_READ;
      rdData <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        kindQ  <= reqWrite ? KIND_WRITE : (reqProg ? KIND_PROG : KIND_READ);
      end
      if (ctl.capture) rdData <= adIn;
    end
  end

  // one active-low strobe per cycle kind
  for (genvar g = 0; g < NUM_STROBES; g++) begin : gStrobe
    assign strbN[g] = !(ctl.strobe && (kindQ == 2'(g)));
  end

  assign psenLvl = strbN[KIND_PROG];
  assign rdLvl   = strbN[KIND_READ];
  assign wrLvl   = strbN[KIND_WRITE];
  assign aleLvl  = ctl.ale;
  assign addrHi  = addrQ[ADDR_W-1 -: HI_W];
  assign adOut   = ctl.driveAddr ? addrQ[DATA_W-1:0] : wdataQ;
  assign adOe    = ctl.driveAddr || (ctl.driveData && (kindQ == KIND_WRITE));

endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int ALE_LEN       = 3,
  parameter int GAP_LEN       = 1,
  parameter int STRB_LEN      = 4,
  parameter int INT_ROM_BYTES = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              floatCtl,
  input  logic              extFetchN,
  input  logic              reqValid,
  input  logic              reqProg,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  input  logic              readyIn,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic              aleOut,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              strobeOe
);

  pathCtl_t ctl;
  logic aleLvl, psenLvl, rdLvl, wrLvl, pathOe;

  membus_fsm #(
    .ADDR_W(ADDR_W), .ALE_LEN(ALE_LEN), .GAP_LEN(GAP_LEN),
    .STRB_LEN(STRB_LEN), .INT_ROM_BYTES(INT_ROM_BYTES)
  ) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqProg(reqProg),
    .reqAddr(reqAddr), .extFetchN(extFetchN), .readyIn(readyIn),
    .ctl(ctl), .busy(busy), .done(done)
  );

  membus_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .reqProg(reqProg),
    .adIn(adIn), .adOut(adOut), .adOe(pathOe), .addrHi(addrHi),
    .aleLvl(aleLvl), .psenLvl(psenLvl), .rdLvl(rdLvl), .wrLvl(wrLvl),
    .rdData(rdData)
  );

  // reset forces all control strobes high; floatCtl picks drive or release
  assign aleOut   = rstN ? aleLvl  : 1'b1;
  assign psenN    = rstN ? psenLvl : 1'b1;
  assign rdN      = rstN ? rdLvl   : 1'b1;
  assign wrN      = rstN ? wrLvl   : 1'b1;
  assign strobeOe = rstN | floatCtl;
  assign adOe     = rstN & pathOe;

endmodule

// File: rtl/membus_checks.sv
module membus_checks #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            floatCtl,
  input logic            busy,
  input logic            done,
  input logic            adOe,
  input logic [HI_W-1:0] addrHi,
  input logic            aleOut,
  input logic            psenN,
  input logic            rdN,
  input logic            wrN,
  input logic            strobeOe
);

  always_comb begin
    if (!rstN && floatCtl === 1'b1) begin
      AST_RESET_DRIVEN: assert (aleOut && psenN && rdN && wrN && strobeOe && !adOe); // R1
    end
    if (!rstN && floatCtl === 1'b0) begin
      AST_RESET_RELEASED: assert (!strobeOe && !adOe); // R1
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (!aleOut && psenN && rdN && wrN && !adOe && strobeOe)); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN) aleOut |-> (psenN && rdN && wrN && adOe)); // R3
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN) $countones({!psenN, !rdN, !wrN}) <= 1); // R5
  AST_HIGH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN) (!psenN || !rdN || !wrN) |=> ((psenN && rdN && wrN) || $stable(addrHi))); // R5
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN) !wrN |-> adOe); // R6
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN) (!rdN || !psenN) |-> !adOe); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R9

endmodule

bind membus_ctrl membus_checks #(.HI_W(ADDR_W - DATA_W)) uChecks (
  .clk(clk), .rstN(rstN), .floatCtl(floatCtl), .busy(busy), .done(done),
  .adOe(adOe), .addrHi(addrHi), .aleOut(aleOut), .psenN(psenN),
  .rdN(rdN), .wrN(wrN), .strobeOe(strobeOe)
);

// File: tb/membus_ctrl_test.sv
module membus_ctrl_test;

  typedef struct {
    int         kind;      // 0 fetch, 1 read, 2 write
    logic [15:0] addr;
    logic [7:0] wdata;
    int         waits;
    bit         internal;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic floatCtl = 1'b1;
  logic extFetchN = 1'b0;
  logic reqValid = 1'b0;
  logic reqProg = 1'b0;
  logic reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic readyIn = 1'b1;
  logic busy, done, adOe, aleOut, psenN, rdN, wrN, strobeOe;
  logic [7:0] rdData, adOut, adIn, addrHi;

  int checks = 0;
  int errors = 0;
  int waitsLeft = 0;
  logic [7:0] curWdata = '0;
  logic [7:0] latchLow = '0;
  item_t expQ[$];

  always #10 clk = ~clk;

  membus_ctrl uut (
    .clk(clk), .rstN(rstN), .floatCtl(floatCtl), .extFetchN(extFetchN),
    .reqValid(reqValid), .reqProg(reqProg), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdData(rdData), .readyIn(readyIn), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .addrHi(addrHi), .aleOut(aleOut), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .strobeOe(strobeOe)
  );

  function automatic logic [7:0] memVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external memory model: address latch plus read response
  always @(negedge aleOut) latchLow = adOut;
  assign adIn = (!rdN || !psenN) ? memVal({addrHi, latchLow}) : 8'h00;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor state
  bit active = 0;
  int cyc, aleCnt, sc0, sc1, sc2, relBad, wrBad, hiBad;
  bit gapOk;
  logic [7:0] seenLow, seenHi;

  always @(negedge clk) begin
    if (!rstN) begin
      active = 0;
    end else begin
      if (busy && !active) begin
        active = 1; cyc = 0; aleCnt = 0; sc0 = 0; sc1 = 0; sc2 = 0;
        relBad = 0; wrBad = 0; hiBad = 0; gapOk = 0;
        seenLow = 8'hxx; seenHi = 8'hxx;
      end else if (active) begin
        cyc++;
      end
      if (active) begin
        if (aleOut) begin aleCnt++; seenLow = adOut; seenHi = addrHi; end
        if (cyc == 3)
          gapOk = !aleOut && psenN && rdN && wrN && adOe && (adOut == seenLow);
        if (!psenN) sc0++;
        if (!rdN) sc1++;
        if (!wrN) sc2++;
        if ((!psenN || !rdN) && adOe) relBad++;
        if (!wrN && (!adOe || adOut != curWdata)) wrBad++;
        if ((!psenN || !rdN || !wrN) && addrHi != seenHi) hiBad++;
        if ((sc0 + sc1 + sc2) >= 4 && waitsLeft > 0) begin
          readyIn = 1'b0; waitsLeft--;
        end else begin
          readyIn = 1'b1;
        end
        if (done) begin
          item_t e;
          if (expQ.size() == 0) begin
            chk("R9 unexpected done", 1, 0);
          end else begin
            e = expQ.pop_front();
            chk("R9 busy during done", busy, 1);
            if (e.internal) begin
              chk("R10 internal fetch latency", cyc, 0);
              chk("R10 internal fetch no strobe", aleCnt + sc0 + sc1 + sc2, 0);
            end else begin
              chk("R9 done latency", cyc, 8 + e.waits);
              chk("R3 latch pulse length", aleCnt, 3);
              chk("R3 latched address", {seenHi, seenLow}, e.addr);
              chk("R4 gap cycle", gapOk, 1);
              chk("R5 fetch strobe count", sc0, (e.kind == 0) ? 4 + e.waits : 0);
              chk("R5 read strobe count", sc1, (e.kind == 1) ? 4 + e.waits : 0);
              chk("R5 write strobe count", sc2, (e.kind == 2) ? 4 + e.waits : 0);
              if (e.waits > 0) chk("R8 stretched strobe", sc0 + sc1 + sc2, 4 + e.waits);
              chk("R5 high address held", hiBad, 0);
              if (e.kind == 2) begin
                chk("R6 write data during strobe", wrBad, 0);
                chk("R6 write data in hold", (adOe && adOut == e.wdata) ? 1 : 0, 1);
              end else begin
                chk("R7 read data", rdData, memVal(e.addr));
                chk("R7 bus released", relBad, 0);
              end
            end
          end
          active = 0;
        end
      end
    end
  end

  task automatic issue(input int kind, input logic [15:0] addr,
                       input logic [7:0] wdata, input int waits, input logic extN);
    item_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    extFetchN = extN;
    reqProg   = (kind == 0);
    reqWrite  = (kind == 2);
    reqAddr   = addr;
    reqWdata  = wdata;
    curWdata  = wdata;
    waitsLeft = waits;
    e.kind = kind; e.addr = addr; e.wdata = wdata; e.waits = waits;
    e.internal = (kind == 0) && extN && (addr < 16'h8000);
    expQ.push_back(e);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // watchdog
  int wdCycles = 0;
  always @(posedge clk) begin
    wdCycles++;
    if (wdCycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset behaviour with drive and release
    repeat (3) @(negedge clk);
    chk("R1 strobes high in reset", {aleOut, psenN, rdN, wrN}, 4'hF);
    chk("R1 strobes driven in reset", strobeOe, 1);
    chk("R1 bus released in reset", adOe, 0);
    floatCtl = 1'b0;
    #2;
    chk("R1 strobes floated in reset", strobeOe, 0);
    floatCtl = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R2 idle levels
    chk("R2 idle strobes", {aleOut, psenN, rdN, wrN}, 4'h7);
    chk("R2 idle bus and busy", {adOe, busy, strobeOe}, 3'b001);

    issue(1, 16'h1234, 8'h00, 0, 1'b0);
    issue(2, 16'hABCD, 8'h3C, 0, 1'b0);
    issue(0, 16'h0100, 8'h00, 0, 1'b0);   // R10 forced external fetch
    issue(0, 16'h0100, 8'h00, 0, 1'b1);   // R10 internal fetch
    issue(0, 16'h9000, 8'h00, 0, 1'b1);   // R10 above window
    issue(0, 16'h7FFF, 8'h00, 0, 1'b1);   // R10 window edge
    issue(0, 16'h8000, 8'h00, 1, 1'b1);   // R10 first external address
    issue(1, 16'hFF00, 8'h00, 2, 1'b0);   // R8 two waits
    issue(2, 16'h00FF, 8'hA5, 1, 1'b0);   // R8 write with wait

    // R9 request during a busy cycle is ignored
    begin
      item_t e;
      @(negedge clk);
      reqProg = 1'b0; reqWrite = 1'b0; reqAddr = 16'h5555; waitsLeft = 0;
      e.kind = 1; e.addr = 16'h5555; e.wdata = 8'h00; e.waits = 0; e.internal = 0;
      expQ.push_back(e);
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      reqAddr = 16'h2222; reqWrite = 1'b1; reqValid = 1'b1;
      repeat (2) @(negedge clk);
      reqValid = 1'b0; reqWrite = 1'b0;
      while (expQ.size() != 0) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk("R9 request during busy ignored", {busy, aleOut}, 2'b00);
      end
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule